// File: doc/BRIEF.md
# Associative-Memory Host Port Cycle Decoder

This block sits between the 16-bit host port of a content-addressable memory and its internal resources. On every clock it takes three active-low strobes: port enable, command/data select and write. It names the cycle as a command write, a command read, a data write, a data read or an idle cycle. It then picks the internal destination or source for that cycle. It drives the output enable and the read word, and it raises a one-cycle strobe that tells the data path which comparand, mask or array path to use on a data cycle.

Routing depends on what came before. An instruction word can arm a one-shot override that steers only the next active command cycle. It can raise an address-field flag that sends the next command write to the address register. It can also move the sticky pointers that select the data-cycle target and source. Back-to-back command reads step through the two halves of the status word. A page/device-select comparison decides whether the device takes part in a cycle. The five command registers are held inside the block as plain storage, and they are read back through the override mechanism. The status word, the next-free-address word and the data-read word come in on input ports.

Top module: `cam_port_decoder`

## Requirements
- R1: With `en_n` high the cycle is idle (`cyc_kind`=0): no strobe, no output enable, and no state change. With `en_n` low, `cmd_n`/`wr_n` give 0/0 = command write (1), 0/1 = command read (2), 1/0 = data write (3) and 1/1 = data read (4).
- R2: A command write with no override pending and no address flag loads the instruction decoder. Bits 10:3 are the opcode (0x00 = override, 0x01 = set sticky source, 0x02 = set sticky target), bits 2:0 are the argument code, and bit 11 is the address-field flag.
- R3: After an instruction load with bit 11 set, the next active cycle, if it is a command write, loads the address register instead of the decoder. The flag is then spent.
- R4: An override instruction with code 1 to 5 (1 address, 2 control, 3 page, 4 segment, 5 device select) steers the next active command write or read to that register. Any active cycle spends it, and idle cycles keep it.
- R5: Override code 0 makes the next command read return the `nfa` input. A command write after it still loads the instruction decoder.
- R6: A command read with no override returns status bits 15:0. If the previous active cycle was such a low-half read, the read returns bits 31:16 instead, and the one after that returns the low half again. Any other active cycle resets the sequence to the low half.
- R7: Reset sets both sticky pointers to code 0 (comparand). It clears the pending override, the address flag and the status-half state, and it zeroes the command registers.
- R8: Sticky target codes 0 to 5 (comparand, mask 1, mask 2, array at address, array at next free, array at best match) appear on `dwr_tgt`. Sticky source codes 0 to 3 and 5 appear on `drd_src`. Source code 4 and codes 6 or 7 are ignored.
- R9: When the device-select register differs from the page register and is not 0xFFFF, writes, reads and instruction loads have no effect.
- R10: A device-select value of 0xFFFF accepts writes but blocks every read.
- R11: While the device is deselected, an override aimed at device select is still accepted, and the write that follows lands in device select.
- R12: A command read after override code 6 returns {DEV_ID, sticky source code}. After code 7 it returns the sticky target code, zero-extended.
- R13: `dout_oe` is high only on read cycles of a device that is allowed to read, and `dout` is zero whenever `dout_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en_n | input | 1 | Port enable, active low |
| cmd_n | input | 1 | Low = command cycle, high = data cycle |
| wr_n | input | 1 | Low = write, high = read |
| din | input | DW | Host write word |
| status | input | 2*DW | Status word from the core |
| nfa | input | DW | Next-free-address word from the core |
| data_rdata | input | DW | Word from the selected data source |
| dout | output | DW | Host read word |
| dout_oe | output | 1 | Bus drive enable |
| cyc_kind | output | 3 | Cycle class code |
| dwr_stb | output | 1 | Data write accepted this cycle |
| dwr_tgt | output | 3 | Sticky data-write target code |
| drd_stb | output | 1 | Data read accepted this cycle |
| drd_src | output | 3 | Sticky data-read source code |

## Verification
A wrong pending override or a stale address flag shows up on the very next active command cycle. It appears as a wrong word on a readback, or as a register that silently keeps its old value. A wrong status-half bit shows on the next command read as the wrong half of `status`. A corrupt sticky pointer shows at once on `dwr_tgt` or `drd_src`. Because the bench model is compared on every clock, any of these faults is reported in the cycle where it first reaches a port.

// File: rtl/cam_port_pkg.sv
package cam_port_pkg;

   typedef enum logic [2:0] {
      CYC_IDLE = 3'd0,
      CYC_CW   = 3'd1,
      CYC_CR   = 3'd2,
      CYC_DW   = 3'd3,
      CYC_DR   = 3'd4
   } cyc_e;

   localparam logic [7:0] OPC_OVR  = 8'h00;
   localparam logic [7:0] OPC_PSRC = 8'h01;
   localparam logic [7:0] OPC_PDST = 8'h02;

   localparam int OPC_LSB  = 3;
   localparam int OPC_W    = 8;
   localparam int ARG_W    = 3;
   localparam int FLAG_BIT = 11;

   // override argument codes
   localparam logic [2:0] T_NFA  = 3'd0;
   localparam logic [2:0] T_ADDR = 3'd1;
   localparam logic [2:0] T_CTRL = 3'd2;
   localparam logic [2:0] T_PAGE = 3'd3;
   localparam logic [2:0] T_SEG  = 3'd4;
   localparam logic [2:0] T_DSEL = 3'd5;
   localparam logic [2:0] T_PSRC = 3'd6;
   localparam logic [2:0] T_PDST = 3'd7;

   // sticky data path codes
   localparam logic [2:0] P_CMP     = 3'd0;
   localparam logic [2:0] P_ARR_NFA = 3'd4;
   localparam logic [2:0] P_LAST    = 3'd5;

   function automatic logic pdst_ok(input logic [2:0] c);
      return c <= P_LAST;
   endfunction

   function automatic logic psrc_ok(input logic [2:0] c);
      return (c <= P_LAST) && (c != P_ARR_NFA);
   endfunction

   function automatic logic is_creg(input logic [2:0] c);
      return (c >= T_ADDR) && (c <= T_DSEL);
   endfunction

endpackage

// File: rtl/cam_cycle_classify.sv
module cam_cycle_classify
   import cam_port_pkg::*;
(
   input  logic en_n,
   input  logic cmd_n,
   input  logic wr_n,
   output cyc_e kind
);
   always_comb begin
      if (en_n)                  kind = CYC_IDLE;
      else if (!cmd_n && !wr_n)  kind = CYC_CW;
      else if (!cmd_n)           kind = CYC_CR;
      else if (!wr_n)            kind = CYC_DW;
      else                       kind = CYC_DR;
   end
endmodule

// File: rtl/cam_sel_gate.sv
module cam_sel_gate #(
   parameter int DW          = 16,
   parameter bit FFFF_WRITES = 1'b1
) (
   input  logic [DW-1:0] page_q,
   input  logic [DW-1:0] dsel_q,
   output logic          wr_ok,
   output logic          rd_ok
);
   logic match;
   assign match = (page_q == dsel_q);

   generate
      if (FFFF_WRITES) begin : g_bcast
         logic all_ones;
         assign all_ones = &dsel_q;
         assign wr_ok    = match || all_ones;
         assign rd_ok    = match && !all_ones;
      end else begin : g_strict
         assign wr_ok = match;
         assign rd_ok = match;
      end
   endgenerate
endmodule

// File: rtl/cam_cmd_regs.sv
module cam_cmd_regs #(
   parameter int DW   = 16,
   parameter int NREG = 5
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   we,
   input  logic [2:0]             idx,
   input  logic [DW-1:0]          wdata,
   output logic [NREG:1][DW-1:0]  q
);
   generate
      for (genvar i = 1; i <= NREG; i++) begin : g_reg
         logic [DW-1:0] r;
         always_ff @(posedge clk) begin
            if (rst)                        r <= '0;
            else if (we && idx == 3'(i))    r <= wdata;
         end
         assign q[i] = r;
      end
   endgenerate
endmodule

// File: rtl/cam_route_ctl.sv
module cam_route_ctl
   import cam_port_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  cyc_e          kind,
   input  logic [DW-1:0] din,
   input  logic          wr_ok,
   input  logic          rd_ok,
   output logic          reg_we,
   output logic [2:0]    reg_idx,
   output logic          os_vld_q,
   output logic [2:0]    os_code_q,
   output logic          st_hi_q,
   output logic [2:0]    psrc_q,
   output logic [2:0]    pdst_q
);
   logic             af_q;
   logic             to_instr;
   logic             ins_ld;
   logic             dsel_ovr;
   logic [OPC_W-1:0] opc;
   logic [ARG_W-1:0] arg;

   assign opc = din[OPC_LSB +: OPC_W];
   assign arg = din[ARG_W-1:0];

   always_comb begin
      to_instr = 1'b0;
      reg_we   = 1'b0;
      reg_idx  = T_ADDR;
      if (kind == CYC_CW) begin
         if (os_vld_q && is_creg(os_code_q)) begin
            reg_idx = os_code_q;
            reg_we  = wr_ok || (os_code_q == T_DSEL);
         end else if (af_q) begin
            reg_idx = T_ADDR;
            reg_we  = wr_ok;
         end else begin
            to_instr = 1'b1;
         end
      end
   end

   assign ins_ld   = to_instr && wr_ok;
   assign dsel_ovr = to_instr && (opc == OPC_OVR) && (arg == T_DSEL);

   always_ff @(posedge clk) begin
      if (rst) begin
         os_vld_q  <= 1'b0;
         os_code_q <= T_NFA;
         af_q      <= 1'b0;
         st_hi_q   <= 1'b0;
         psrc_q    <= P_CMP;
         pdst_q    <= P_CMP;
      end else if (kind != CYC_IDLE) begin
         os_vld_q <= 1'b0;
         af_q     <= 1'b0;
         st_hi_q  <= 1'b0;
         if ((ins_ld || dsel_ovr) && opc == OPC_OVR) begin
            os_vld_q  <= 1'b1;
            os_code_q <= arg;
         end
         if (ins_ld) begin
            af_q <= din[FLAG_BIT];
            if (opc == OPC_PSRC && psrc_ok(arg)) psrc_q <= arg;
            if (opc == OPC_PDST && pdst_ok(arg)) pdst_q <= arg;
         end
         if (kind == CYC_CR && !os_vld_q && rd_ok)
            st_hi_q <= !st_hi_q;
      end
   end
endmodule

// File: rtl/cam_port_decoder.sv
module cam_port_decoder
   import cam_port_pkg::*;
#(
   parameter int            DW          = 16,
   parameter bit            FFFF_WRITES = 1'b1,
   parameter logic [DW-4:0] DEV_ID      = (DW-3)'(16'h00A5)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            en_n,
   input  logic            cmd_n,
   input  logic            wr_n,
   input  logic [DW-1:0]   din,
   input  logic [2*DW-1:0] status,
   input  logic [DW-1:0]   nfa,
   input  logic [DW-1:0]   data_rdata,
   output logic [DW-1:0]   dout,
   output logic            dout_oe,
   output logic [2:0]      cyc_kind,
   output logic            dwr_stb,
   output logic [2:0]      dwr_tgt,
   output logic            drd_stb,
   output logic [2:0]      drd_src
);
   localparam int N_CREG = 5;
   localparam int SPAN_W = DW - ARG_W;

   generate
      if (DW < FLAG_BIT + 1) begin : g_chk_dw
         $error("cam_port_decoder: DW must hold the address-field flag bit");
      end
   endgenerate

   cyc_e                    kind;
   logic                    wr_ok, rd_ok;
   logic                    reg_we;
   logic [2:0]              reg_idx;
   logic                    os_vld, st_hi;
   logic [2:0]              os_code, psrc, pdst;
   logic [N_CREG:1][DW-1:0] creg;
   logic [DW-1:0]           page_w, dsel_w, cr_word;
   logic                    is_read;

   cam_cycle_classify u_cls (
      .en_n (en_n), .cmd_n (cmd_n), .wr_n (wr_n), .kind (kind)
   );

   assign page_w = creg[T_PAGE];
   assign dsel_w = creg[T_DSEL];

   cam_sel_gate #(.DW(DW), .FFFF_WRITES(FFFF_WRITES)) u_gate (
      .page_q (page_w), .dsel_q (dsel_w), .wr_ok (wr_ok), .rd_ok (rd_ok)
   );

   cam_route_ctl #(.DW(DW)) u_route (
      .clk (clk), .rst (rst), .kind (kind), .din (din),
      .wr_ok (wr_ok), .rd_ok (rd_ok),
      .reg_we (reg_we), .reg_idx (reg_idx),
      .os_vld_q (os_vld), .os_code_q (os_code), .st_hi_q (st_hi),
      .psrc_q (psrc), .pdst_q (pdst)
   );

   cam_cmd_regs #(.DW(DW), .NREG(N_CREG)) u_regs (
      .clk (clk), .rst (rst), .we (reg_we), .idx (reg_idx),
      .wdata (din), .q (creg)
   );

   always_comb begin
      if (os_vld) begin
         case (os_code)
            T_NFA:   cr_word = nfa;
            T_ADDR:  cr_word = creg[1];
            T_CTRL:  cr_word = creg[2];
            T_PAGE:  cr_word = creg[3];
            T_SEG:   cr_word = creg[4];
            T_DSEL:  cr_word = creg[5];
            T_PSRC:  cr_word = {DEV_ID, psrc};
            default: cr_word = {{SPAN_W{1'b0}}, pdst};
         endcase
      end else begin
         cr_word = st_hi ? status[2*DW-1:DW] : status[DW-1:0];
      end
   end

   assign is_read  = (kind == CYC_CR) || (kind == CYC_DR);
   assign dout_oe  = is_read && rd_ok;
   assign dout     = !dout_oe ? '0 : (kind == CYC_DR) ? data_rdata : cr_word;
   assign cyc_kind = kind;
   assign dwr_stb  = (kind == CYC_DW) && wr_ok;
   assign drd_stb  = (kind == CYC_DR) && rd_ok;
   assign dwr_tgt  = pdst;
   assign drd_src  = psrc;
endmodule

// File: rtl/cam_port_checker.sv
module cam_port_checker #(
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst,
   input logic          en_n,
   input logic [2:0]    cyc_kind,
   input logic          dout_oe,
   input logic          dwr_stb,
   input logic          drd_stb,
   input logic [2:0]    dwr_tgt,
   input logic [2:0]    drd_src,
   input logic [DW-1:0] page_q,
   input logic [DW-1:0] dsel_q
);
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
      en_n |-> (!dout_oe && !dwr_stb && !drd_stb)); // R1
   AST_OE_ON_READS: assert property (@(posedge clk) disable iff (rst)
      dout_oe |-> (cyc_kind == 3'd2 || cyc_kind == 3'd4)); // R13
   AST_BCAST_NO_READ: assert property (@(posedge clk) disable iff (rst)
      (&dsel_q) |-> (!dout_oe && !drd_stb)); // R10
   AST_DESEL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
      (dsel_q != page_q && !(&dsel_q)) |-> (!dwr_stb && !dout_oe)); // R9
   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
      (cyc_kind != 3'd1) |=> ($stable(dwr_tgt) && $stable(drd_src))); // R8
   AST_RESET_CMP: assert property (@(posedge clk)
      rst |=> (dwr_tgt == 3'd0 && drd_src == 3'd0)); // R7
endmodule

bind cam_port_decoder cam_port_checker #(.DW(DW)) u_chk (
   .clk (clk), .rst (rst), .en_n (en_n), .cyc_kind (cyc_kind),
   .dout_oe (dout_oe), .dwr_stb (dwr_stb), .drd_stb (drd_stb),
   .dwr_tgt (dwr_tgt), .drd_src (drd_src),
   .page_q (page_w), .dsel_q (dsel_w)
);

// File: tb/sim_cam_port_decoder.sv
module sim_cam_port_decoder;
   localparam logic [31:0] STAT = 32'hA1B2_C3D4;
   localparam logic [15:0] NFAV = 16'h0777;
   localparam logic [15:0] RDV  = 16'h5A5A;
   localparam int          DEVV = 'h0A5;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        en_n = 1'b1, cmd_n = 1'b1, wr_n = 1'b1;
   logic [15:0] din = '0;
   logic [15:0] dout;
   logic        dout_oe, dwr_stb, drd_stb;
   logic [2:0]  cyc_kind, dwr_tgt, drd_src;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   // reference state
   int          m_os_v, m_os_c, m_af, m_st, m_sps, m_spd;
   logic [15:0] m_reg [6];

   always #10 clk = ~clk;

   cam_port_decoder u0 (
      .clk (clk), .rst (rst), .en_n (en_n), .cmd_n (cmd_n), .wr_n (wr_n),
      .din (din), .status (STAT), .nfa (NFAV), .data_rdata (RDV),
      .dout (dout), .dout_oe (dout_oe), .cyc_kind (cyc_kind),
      .dwr_stb (dwr_stb), .dwr_tgt (dwr_tgt), .drd_stb (drd_stb),
      .drd_src (drd_src)
   );

   task automatic model_reset();
      m_os_v = 0; m_os_c = 0; m_af = 0; m_st = 0; m_sps = 0; m_spd = 0;
      for (int i = 0; i < 6; i++) m_reg[i] = '0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1; en_n = 1'b1;
      @(negedge clk); rst = 1'b0;
      model_reset();
   endtask

   // one bus cycle: drive, compare against the model, advance the model
   task automatic step(input bit e, input bit c, input bit w,
                       input logic [15:0] d, input string req);
      int kind, op, tg, o_v, o_c, o_af, o_st;
      bit wok, rok, x_oe, x_ws, x_rs;
      logic [15:0] x_d;
      @(negedge clk);
      en_n = e; cmd_n = c; wr_n = w; din = d;
      #5;
      kind = e ? 0 : (!c && !w) ? 1 : !c ? 2 : !w ? 3 : 4;
      wok = (m_reg[5] == m_reg[3]) || (m_reg[5] == 16'hFFFF);
      rok = (m_reg[5] == m_reg[3]) && (m_reg[5] != 16'hFFFF);
      x_oe = (kind == 2 || kind == 4) && rok;
      x_ws = (kind == 3) && wok;
      x_rs = (kind == 4) && rok;
      x_d  = '0;
      if (x_oe && kind == 4) x_d = RDV;
      else if (x_oe) begin
         if (m_os_v != 0) begin
            if (m_os_c == 0)      x_d = NFAV;
            else if (m_os_c <= 5) x_d = m_reg[m_os_c];
            else if (m_os_c == 6) x_d = 16'((DEVV << 3) | m_sps);
            else                  x_d = 16'(m_spd);
         end else x_d = (m_st != 0) ? STAT[31:16] : STAT[15:0];
      end
      n_chk++;
      if (cyc_kind !== 3'(kind) || dout_oe !== x_oe || dout !== x_d ||
          dwr_stb !== x_ws || drd_stb !== x_rs ||
          dwr_tgt !== 3'(m_spd) || drd_src !== 3'(m_sps)) begin
         n_bad++;
         $display("FAIL %s: got kind=%0d oe=%0b dout=%h ws=%0b rs=%0b tgt=%0d src=%0d exp kind=%0d oe=%0b dout=%h ws=%0b rs=%0b tgt=%0d src=%0d",
                  req, cyc_kind, dout_oe, dout, dwr_stb, drd_stb, dwr_tgt, drd_src,
                  kind, x_oe, x_d, x_ws, x_rs, m_spd, m_sps);
      end
      if (kind != 0) begin
         o_v = m_os_v; o_c = m_os_c; o_af = m_af; o_st = m_st;
         m_os_v = 0; m_af = 0; m_st = 0;
         if (kind == 1) begin
            if (o_v != 0 && o_c >= 1 && o_c <= 5) begin
               if (wok || o_c == 5) m_reg[o_c] = d;
            end else if (o_af != 0) begin
               if (wok) m_reg[1] = d;
            end else begin
               op = (d >> 3) & 255; tg = d & 7;
               if (wok) begin
                  if (op == 0) begin m_os_v = 1; m_os_c = tg; end
                  if (op == 1 && tg != 4 && tg <= 5) m_sps = tg;
                  if (op == 2 && tg <= 5) m_spd = tg;
                  m_af = d[11];
               end else if (op == 0 && tg == 5) begin
                  m_os_v = 1; m_os_c = 5;
               end
            end
         end
         if (kind == 2 && o_v == 0 && rok) m_st = (o_st == 0) ? 1 : 0;
      end
   endtask

   task automatic cw(input logic [15:0] d, input string r); step(0, 0, 0, d, r); endtask
   task automatic cr(input string r); step(0, 0, 1, 16'h0, r); endtask
   task automatic dw(input string r); step(0, 1, 0, 16'hCAFE, r); endtask
   task automatic dr(input string r); step(0, 1, 1, 16'h0, r); endtask
   task automatic idle(input string r); step(1, 0, 0, 16'hFFFF, r); endtask

   initial begin
      model_reset();
      do_reset();
      // R7 reset state, R1 classification
      idle("R7"); dw("R7"); dr("R7"); cr("R1"); idle("R1");
      // R6 status halves
      cr("R6"); cr("R6"); cr("R6"); cr("R6"); dw("R6"); cr("R6");
      idle("R6"); cr("R6"); cr("R6");
      // R2/R4 override to address register, held over idle
      cw(16'h0001, "R2"); idle("R4"); cw(16'h1234, "R4");
      cw(16'h0001, "R4"); cr("R4"); cr("R4");
      // R3 address-field flag then spent
      cw(16'h0880, "R3"); cw(16'hBEEF, "R3"); cw(16'h0001, "R3"); cr("R3");
      // R5 override code 0
      cw(16'h0000, "R5"); cr("R5"); cw(16'h0000, "R5"); cw(16'h0002, "R5");
      cw(16'h5555, "R5"); cw(16'h0002, "R5"); cr("R5");
      // R8 sticky pointers
      cw(16'h0012, "R8"); dw("R8"); cw(16'h000B, "R8"); dr("R8");
      cw(16'h000C, "R8"); dr("R8"); cw(16'h0014, "R8"); dw("R8");
      cw(16'h0017, "R8"); dw("R8"); cw(16'h000E, "R8"); dr("R8");
      // R12 pointer readback
      cw(16'h0006, "R12"); cr("R12"); cw(16'h0007, "R12"); cr("R12");
      // R10 broadcast select value
      cw(16'h0005, "R10"); cw(16'hFFFF, "R10"); cr("R10"); dw("R10"); dr("R10");
      cw(16'h0003, "R10"); cw(16'h0042, "R10");
      // R9 deselected device
      cw(16'h0005, "R9"); cw(16'h0007, "R9"); cr("R9"); dw("R9"); dr("R9");
      cw(16'h0011, "R9"); cw(16'h0001, "R9"); cw(16'h9999, "R9");
      // R11 device-select override while deselected
      cw(16'h0005, "R11"); cw(16'h0042, "R11"); cr("R11"); dw("R11");
      cw(16'h0001, "R9"); cr("R9");
      // R13 drive only on reads
      dw("R13"); cw(16'h0040, "R13"); idle("R13"); dr("R13");
      // R7 reset clears pending override and pointers
      cw(16'h0001, "R7");
      do_reset();
      cr("R7"); dw("R7"); dr("R7"); cr("R7");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   end
endmodule